// File: doc/BRIEF.md
# Block Protection Controller Configuration Registers

This block is the software-visible register bank of a memory protection controller that divides memory into fixed-size blocks and keeps one security bit per block. It sits on a 32-bit APB-style slave port with byte strobes and an access-size qualifier. It holds:

- a control word with an error-response select, an auto-increment flag and a sticky lockdown flag;
- a table of per-block security words, reached through a single data window whose pointer steps forward on whole-word accesses;
- an interrupt status, enable and two fault-information registers.

The checking logic beside it reads the table through a separate combinational read port. Fault details are loaded from that checking logic through a capture strobe. The block combines the interrupt status and enable into one interrupt line.

Software typically fills the table by writing the pointer once and then streaming whole words into the window. It then sets lockdown, which freezes the control word, the table and the interrupt enable until the next reset.

Top module: `prot_cfg_regs`

## Requirements
- R1: The register is selected by word offset, with paddr[1:0] ignored. The offsets are control 0x00, table size 0x10, block grain 0x14, window pointer 0x18, window data 0x1C, irq status 0x20, irq clear 0x24, irq enable 0x28, fault info 0 0x2C, fault info 1 0x30 and irq set 0x34. Reads of any other offset return 0, and writes to them have no effect.
- R2: The control word keeps only bit 4 (error response), bit 8 (auto-increment) and bit 31 (lockdown). All other bits read 0 whatever was written.
- R3: Synchronous reset sets the control word to 0x0000_0100, irq enable to 1, and the pointer, irq status, both fault words and every table word to 0.
- R4: While control bit 31 is 1, writes to the control word, window data and irq enable are dropped and leave those registers and the pointer unchanged. Only reset clears bit 31.
- R5: The table-size register reads NWORDS. A write to the window pointer stores the merged written value modulo NWORDS.
- R6: A window-data access reads or writes the table word at the pointer. An access with psize=2 (word) then advances the pointer by one, wrapping from NWORDS-1 to 0. Byte (psize=0) and halfword (psize=1) accesses leave the pointer unchanged.
- R7: A write to control, window pointer or window data replaces only the byte lanes whose pstrb bit is 1 and keeps the other bytes. Writes to any other register take the unstrobed bytes as zero.
- R8: The block-grain register reads log2(BLK_BYTES) - 5.
- R9: Writing a value with bit 0 set to irq set makes the status 1. Doing the same to irq clear makes it 0. Irq enable stores bit 0 only.
- R10: irq equals status AND enable, and it follows either register in the same cycle the register changes.
- R11: Writes to table size, block grain, irq status and both fault-info registers have no effect.
- R12: When cap_valid is 1 and the irq status is 0, the fault words load cap_info0 and cap_info1 on that clock edge. While the status is 1, the fault words hold.
- R13: lut_rd_word shows the table word at lut_rd_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| psize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte lanes |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| cap_valid | input | 1 | Fault capture strobe |
| cap_info0 | input | 32 | Fault detail loaded into fault info 0 |
| cap_info1 | input | 32 | Fault detail loaded into fault info 1 |
| irq | output | 1 | Interrupt request |
| lut_rd_idx | input | IDX_W | Table word index for the checking logic |
| lut_rd_word | output | 32 | Table word at lut_rd_idx |

## Verification
The assertions check these on every cycle:
- lockdown stays set once it is set;
- a locked write leaves the window word, the pointer and the enable untouched;
- the pointer never leaves the table and holds across narrow window accesses;
- set and clear requests reach the status on the next cycle;
- the fault words freeze while the status is set.

Only the bench scenarios show the following:
- the stored values themselves: byte-lane merging against zero-filling, the modulo on pointer writes and the wrap after a full pass of the table;
- read-only and unmapped offsets;
- capture accepted while the status is clear;
- the complete reset state read back through the bus and the table read port.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

    // Word offsets (byte offset >> 2); software decodes these.
    localparam logic [31:0] WOFS_CONTROL    = 32'd0;
    localparam logic [31:0] WOFS_NWORDS     = 32'd4;
    localparam logic [31:0] WOFS_GRAIN      = 32'd5;
    localparam logic [31:0] WOFS_WINPTR     = 32'd6;
    localparam logic [31:0] WOFS_WINDATA    = 32'd7;
    localparam logic [31:0] WOFS_IRQ_STATUS = 32'd8;
    localparam logic [31:0] WOFS_IRQ_CLR    = 32'd9;
    localparam logic [31:0] WOFS_IRQ_MASK   = 32'd10;
    localparam logic [31:0] WOFS_FAULT0     = 32'd11;
    localparam logic [31:0] WOFS_FAULT1     = 32'd12;
    localparam logic [31:0] WOFS_IRQ_SET    = 32'd13;

    localparam int CTRL_ERRRESP_BIT = 4;
    localparam int CTRL_AUTOINC_BIT = 8;
    localparam int CTRL_LOCK_BIT    = 31;

    localparam logic [31:0] CTRL_KEEP  = (32'd1 << CTRL_ERRRESP_BIT)
                                       | (32'd1 << CTRL_AUTOINC_BIT)
                                       | (32'd1 << CTRL_LOCK_BIT);
    localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CONTROL,
        SEL_NWORDS,
        SEL_GRAIN,
        SEL_WINPTR,
        SEL_WINDATA,
        SEL_IRQ_STATUS,
        SEL_IRQ_CLR,
        SEL_IRQ_MASK,
        SEL_FAULT0,
        SEL_FAULT1,
        SEL_IRQ_SET
    } reg_sel_e;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic        full;
        reg_sel_e    sel;
        logic [3:0]  strb;
        logic [31:0] wdata;
    } bus_op_t;

    // Replace the strobed byte lanes of cur with those of nv.
    function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                               input logic [31:0] nv,
                                               input logic [3:0]  strb);
        logic [31:0] r;
        r = cur;
        for (int b = 0; b < 4; b++) begin
            if (strb[b]) r[b*8 +: 8] = nv[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic reg_sel_e decode_word(input logic [31:0] w);
        reg_sel_e s;
        case (w)
            WOFS_CONTROL:    s = SEL_CONTROL;
            WOFS_NWORDS:     s = SEL_NWORDS;
            WOFS_GRAIN:      s = SEL_GRAIN;
            WOFS_WINPTR:     s = SEL_WINPTR;
            WOFS_WINDATA:    s = SEL_WINDATA;
            WOFS_IRQ_STATUS: s = SEL_IRQ_STATUS;
            WOFS_IRQ_CLR:    s = SEL_IRQ_CLR;
            WOFS_IRQ_MASK:   s = SEL_IRQ_MASK;
            WOFS_FAULT0:     s = SEL_FAULT0;
            WOFS_FAULT1:     s = SEL_FAULT1;
            WOFS_IRQ_SET:    s = SEL_IRQ_SET;
            default:         s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/prot_cfg_decode.sv
module prot_cfg_decode
    import prot_cfg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [1:0]        psize,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [3:0]        pstrb,
    output bus_op_t           op
);
    // R1: byte-lane address bits do not take part in register selection
    logic addr_lsb_unused;
    assign addr_lsb_unused = ^paddr[1:0];

    always_comb begin
        op.wr    = psel && penable && pwrite;
        op.rd    = psel && penable && !pwrite;
        op.full  = (psize == SIZE_WORD);
        op.sel   = decode_word(32'(paddr[ADDR_W-1:2]));
        op.strb  = pstrb;
        op.wdata = pwdata;
    end
endmodule

// File: rtl/prot_cfg_lut.sv
module prot_cfg_lut
    import prot_cfg_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock,
    input  logic             data_wr_req,
    input  logic             data_rd_req,
    input  logic             ptr_wr,
    input  logic             full,
    input  logic [3:0]       strb,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] idx,
    output logic [31:0]      win_word,
    output logic [31:0]      rd_word
);
    localparam logic [31:0]      NW32 = 32'(NWORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

    logic [31:0]      mem_q [NWORDS];
    logic [IDX_W-1:0] idx_q;
    logic             data_wr;
    logic             step;
    logic [31:0]      ptr_merged;
    logic [31:0]      ptr_mod;
    logic [IDX_W-1:0] idx_inc;

    assign data_wr    = data_wr_req && !lock;               // R4
    assign step       = (data_wr || data_rd_req) && full;   // R6
    assign ptr_merged = lane_merge(32'(idx_q), wdata, strb); // R7
    assign ptr_mod    = ptr_merged % NW32;                   // R5
    assign idx_inc    = (idx_q == LAST) ? '0 : idx_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (ptr_wr) idx_q <= ptr_mod[IDX_W-1:0];
        else if (step)   idx_q <= idx_inc;
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (data_wr && idx_q == IDX_W'(g))
                mem_q[g] <= lane_merge(mem_q[g], wdata, strb);
        end
    end

    assign idx      = idx_q;
    assign win_word = mem_q[idx_q];
    assign rd_word  = (32'(rd_idx) < NW32) ? mem_q[rd_idx] : '0; // R13

    a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        32'(idx_q) < NW32);
    a_r6_narrow_holds_ptr: assert property (@(posedge clk) disable iff (rst)
        ((data_wr_req || data_rd_req) && !full && !ptr_wr) |=> $stable(idx_q));
    a_r6_wraps_at_end: assert property (@(posedge clk) disable iff (rst)
        ((data_wr || data_rd_req) && full && idx_q == LAST) |=> idx_q == '0);
    a_r4_locked_window: assert property (@(posedge clk) disable iff (rst)
        (data_wr_req && lock) |=> ($stable(win_word) && $stable(idx_q)));
endmodule

// File: rtl/prot_cfg_irq.sv
module prot_cfg_irq (
    input  logic        clk,
    input  logic        rst,
    input  logic        lock,
    input  logic        set_req,
    input  logic        clr_req,
    input  logic        mask_wr_req,
    input  logic        wbit0,
    input  logic        cap_valid,
    input  logic [31:0] cap_info0,
    input  logic [31:0] cap_info1,
    output logic        status,
    output logic        enable,
    output logic [31:0] info0,
    output logic [31:0] info1,
    output logic        irq
);
    logic        stat_q;
    logic        en_q;
    logic [31:0] info0_q;
    logic [31:0] info1_q;

    // R9: status set/clear
    always_ff @(posedge clk) begin
        if (rst)          stat_q <= 1'b0;
        else if (set_req) stat_q <= 1'b1;
        else if (clr_req) stat_q <= 1'b0;
    end

    // R9 / R4: enable keeps bit 0, frozen under lockdown
    always_ff @(posedge clk) begin
        if (rst)                       en_q <= 1'b1;
        else if (mask_wr_req && !lock) en_q <= wbit0;
    end

    // R12: capture only while no interrupt is pending
    always_ff @(posedge clk) begin
        if (rst) begin
            info0_q <= '0;
            info1_q <= '0;
        end else if (cap_valid && !stat_q) begin
            info0_q <= cap_info0;
            info1_q <= cap_info1;
        end
    end

    assign status = stat_q;
    assign enable = en_q;
    assign info0  = info0_q;
    assign info1  = info1_q;
    assign irq    = stat_q && en_q; // R10

    a_r9_set_reaches_status: assert property (@(posedge clk) disable iff (rst)
        set_req |=> stat_q);
    a_r9_clr_reaches_status: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> !stat_q);
    a_r12_info_frozen: assert property (@(posedge clk) disable iff (rst)
        stat_q |=> ($stable(info0_q) && $stable(info1_q)));
    a_r4_enable_locked: assert property (@(posedge clk) disable iff (rst)
        (mask_wr_req && lock) |=> $stable(en_q));
endmodule

// File: rtl/prot_cfg_regs.sv
module prot_cfg_regs
    import prot_cfg_pkg::*;
#(
    parameter  int NWORDS    = 4,
    parameter  int BLK_BYTES = 128,
    parameter  int ADDR_W    = 12,
    localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [1:0]        psize,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [3:0]        pstrb,
    output logic [31:0]       prdata,
    input  logic              cap_valid,
    input  logic [31:0]       cap_info0,
    input  logic [31:0]       cap_info1,
    output logic              irq,
    input  logic [IDX_W-1:0]  lut_rd_idx,
    output logic [31:0]       lut_rd_word
);
    localparam int GRAIN_CODE = $clog2(BLK_BYTES) - 5; // R8

    bus_op_t          op;
    logic [31:0]      ctrl_q;
    logic             lock;
    logic             wbit0;
    logic [IDX_W-1:0] win_idx;
    logic [31:0]      win_word;
    logic             irq_status;
    logic             irq_enable;
    logic [31:0]      fault0;
    logic [31:0]      fault1;
    logic [31:0]      rdata_sel;

    prot_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .psize   (psize),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pstrb   (pstrb),
        .op      (op)
    );

    assign lock  = ctrl_q[CTRL_LOCK_BIT];
    assign wbit0 = op.strb[0] && op.wdata[0]; // R7 zero-fill for bit 0

    // R2 / R4 / R7: control word
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (op.wr && op.sel == SEL_CONTROL && !lock)
            ctrl_q <= lane_merge(ctrl_q, op.wdata, op.strb) & CTRL_KEEP;
    end

    prot_cfg_lut #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_lut (
        .clk         (clk),
        .rst         (rst),
        .lock        (lock),
        .data_wr_req (op.wr && op.sel == SEL_WINDATA),
        .data_rd_req (op.rd && op.sel == SEL_WINDATA),
        .ptr_wr      (op.wr && op.sel == SEL_WINPTR),
        .full        (op.full),
        .strb        (op.strb),
        .wdata       (op.wdata),
        .rd_idx      (lut_rd_idx),
        .idx         (win_idx),
        .win_word    (win_word),
        .rd_word     (lut_rd_word)
    );

    prot_cfg_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .lock        (lock),
        .set_req     (op.wr && op.sel == SEL_IRQ_SET && wbit0),
        .clr_req     (op.wr && op.sel == SEL_IRQ_CLR && wbit0),
        .mask_wr_req (op.wr && op.sel == SEL_IRQ_MASK),
        .wbit0       (wbit0),
        .cap_valid   (cap_valid),
        .cap_info0   (cap_info0),
        .cap_info1   (cap_info1),
        .status      (irq_status),
        .enable      (irq_enable),
        .info0       (fault0),
        .info1       (fault1),
        .irq         (irq)
    );

    // R1 / R5 / R8 / R11: read mux
    always_comb begin
        case (op.sel)
            SEL_CONTROL:    rdata_sel = ctrl_q;
            SEL_NWORDS:     rdata_sel = 32'(NWORDS);
            SEL_GRAIN:      rdata_sel = 32'(GRAIN_CODE);
            SEL_WINPTR:     rdata_sel = 32'(win_idx);
            SEL_WINDATA:    rdata_sel = win_word;
            SEL_IRQ_STATUS: rdata_sel = {31'b0, irq_status};
            SEL_IRQ_MASK:   rdata_sel = {31'b0, irq_enable};
            SEL_FAULT0:     rdata_sel = fault0;
            SEL_FAULT1:     rdata_sel = fault1;
            default:        rdata_sel = '0;
        endcase
        prdata = (psel && !pwrite) ? rdata_sel : '0;
    end

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);
    a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (rst)
        (op.rd && op.sel == SEL_CONTROL) |-> ((prdata & ~CTRL_KEEP) == '0));
    a_r4_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
        (op.wr && op.sel == SEL_CONTROL && lock) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_prot_cfg_regs.sv
`timescale 1ns/1ps
module tb_prot_cfg_regs;
    localparam int NW   = 4;
    localparam int IDXW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [1:0]  psize = 2'd2;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_info0 = '0, cap_info1 = '0;
    logic        irq;
    logic [IDXW-1:0] lut_rd_idx = '0;
    logic [31:0] lut_rd_word;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    prot_cfg_regs dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .psize(psize), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .cap_valid(cap_valid), .cap_info0(cap_info0),
        .cap_info1(cap_info1), .irq(irq), .lut_rd_idx(lut_rd_idx),
        .lut_rd_word(lut_rd_word)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  s;
        logic [1:0]  z;
        logic [31:0] e;
        logic [7:0]  r;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0, 4'h0, 2'd2, 32'h0000_0100, 8'd3},  // R3 control reset
        '{1'b0, 8'h10, 32'h0, 4'h0, 2'd2, 32'h0000_0004, 8'd5},  // R5 table size
        '{1'b0, 8'h14, 32'h0, 4'h0, 2'd2, 32'h0000_0002, 8'd8},  // R8 grain
        '{1'b0, 8'h28, 32'h0, 4'h0, 2'd2, 32'h0000_0001, 8'd3},  // R3 enable reset
        '{1'b0, 8'h18, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd3},  // R3 pointer reset
        '{1'b0, 8'h20, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd3},  // R3 status reset
        '{1'b1, 8'h00, 32'h7FFF_FEFF, 4'hF, 2'd2, 32'h0, 8'd2},
        '{1'b0, 8'h00, 32'h0, 4'h0, 2'd2, 32'h0000_0010, 8'd2},  // R2 kept bits only
        '{1'b1, 8'h1C, 32'hAAAA_0001, 4'hF, 2'd2, 32'h0, 8'd6},
        '{1'b1, 8'h1C, 32'hBBBB_0002, 4'hF, 2'd2, 32'h0, 8'd6},
        '{1'b1, 8'h1C, 32'hCCCC_0003, 4'hF, 2'd2, 32'h0, 8'd6},
        '{1'b1, 8'h1C, 32'hDDDD_0004, 4'hF, 2'd2, 32'h0, 8'd6},
        '{1'b0, 8'h18, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd6},  // R6 wrap
        '{1'b0, 8'h1C, 32'h0, 4'h0, 2'd2, 32'hAAAA_0001, 8'd6},  // R6 word read
        '{1'b0, 8'h1C, 32'h0, 4'h0, 2'd1, 32'hBBBB_0002, 8'd6},  // R6 half read
        '{1'b0, 8'h18, 32'h0, 4'h0, 2'd2, 32'h0000_0001, 8'd6},  // R6 no step
        '{1'b1, 8'h1C, 32'h0000_00EE, 4'h1, 2'd0, 32'h0, 8'd7},
        '{1'b0, 8'h1C, 32'h0, 4'h0, 2'd2, 32'hBBBB_00EE, 8'd7},  // R7 window merge
        '{1'b0, 8'h18, 32'h0, 4'h0, 2'd2, 32'h0000_0002, 8'd6},
        '{1'b1, 8'h18, 32'h0000_0007, 4'hF, 2'd2, 32'h0, 8'd5},
        '{1'b0, 8'h18, 32'h0, 4'h0, 2'd2, 32'h0000_0003, 8'd5},  // R5 modulo
        '{1'b1, 8'h19, 32'h0000_0100, 4'h2, 2'd0, 32'h0, 8'd7},
        '{1'b0, 8'h1A, 32'h0, 4'h0, 2'd2, 32'h0000_0003, 8'd7},  // R7 ptr merge, R1 lsb
        '{1'b1, 8'h00, 32'h0000_0100, 4'h2, 2'd0, 32'h0, 8'd7},
        '{1'b0, 8'h00, 32'h0, 4'h0, 2'd2, 32'h0000_0110, 8'd7},  // R7 control merge
        '{1'b1, 8'h28, 32'h0000_0001, 4'h2, 2'd0, 32'h0, 8'd7},
        '{1'b0, 8'h28, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd7},  // R7 zero fill
        '{1'b1, 8'h28, 32'hFFFF_FFFF, 4'hF, 2'd2, 32'h0, 8'd9},
        '{1'b0, 8'h28, 32'h0, 4'h0, 2'd2, 32'h0000_0001, 8'd9},  // R9 bit 0 only
        '{1'b1, 8'h34, 32'h0000_0001, 4'hF, 2'd2, 32'h0, 8'd9},
        '{1'b0, 8'h20, 32'h0, 4'h0, 2'd2, 32'h0000_0001, 8'd9},  // R9 set
        '{1'b1, 8'h20, 32'h0000_0000, 4'hF, 2'd2, 32'h0, 8'd11},
        '{1'b0, 8'h20, 32'h0, 4'h0, 2'd2, 32'h0000_0001, 8'd11}, // R11 status RO
        '{1'b1, 8'h24, 32'h0000_0002, 4'hF, 2'd2, 32'h0, 8'd9},
        '{1'b0, 8'h20, 32'h0, 4'h0, 2'd2, 32'h0000_0001, 8'd9},  // R9 bit 1 no clear
        '{1'b1, 8'h24, 32'h0000_0001, 4'hF, 2'd2, 32'h0, 8'd9},
        '{1'b0, 8'h20, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd9},  // R9 clear
        '{1'b0, 8'h40, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd1},  // R1 unmapped
        '{1'b0, 8'h0C, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd1},  // R1 unmapped hole
        '{1'b1, 8'h10, 32'h0000_00FF, 4'hF, 2'd2, 32'h0, 8'd11},
        '{1'b0, 8'h10, 32'h0, 4'h0, 2'd2, 32'h0000_0004, 8'd11}, // R11 size RO
        '{1'b1, 8'h14, 32'h0000_00FF, 4'hF, 2'd2, 32'h0, 8'd11},
        '{1'b0, 8'h14, 32'h0, 4'h0, 2'd2, 32'h0000_0002, 8'd11}, // R11 grain RO
        '{1'b1, 8'h2C, 32'h1234_5678, 4'hF, 2'd2, 32'h0, 8'd11},
        '{1'b0, 8'h2C, 32'h0, 4'h0, 2'd2, 32'h0000_0000, 8'd11}  // R11 info RO
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d,
                             input logic [3:0] s, input logic [1:0] z);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1;
        paddr = {4'h0, a}; pwdata = d; pstrb = s; psize = z;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pstrb = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [1:0] z,
                            output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0;
        paddr = {4'h0, a}; pstrb = '0; psize = z;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a,
                              input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, 2'd2, d);
        check(req, d, exp);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset irq", {31'b0, irq}, 32'd0);

        // Table-driven walk: R1 R2 R3 R5 R6 R7 R8 R9 R11
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].a, VEC[i].d, VEC[i].s, VEC[i].z);
            end else begin
                bus_read(VEC[i].a, VEC[i].z, d);
                check($sformatf("R%0d vec %0d", VEC[i].r, i), d, VEC[i].e);
            end
        end
        // Table now 0:AAAA0001 1:BBBB00EE 2:CCCC0003 3:DDDD0004, pointer 3

        // R13 downstream read port
        lut_rd_idx = 2'd2;
        #1 check("R13 read port", lut_rd_word, 32'hCCCC_0003);
        lut_rd_idx = 2'd1;
        #1 check("R13 read port", lut_rd_word, 32'hBBBB_00EE);

        // R10 irq follows status and enable
        bus_write(8'h34, 32'h1, 4'hF, 2'd2);
        check("R10 irq on set", {31'b0, irq}, 32'd1);
        bus_write(8'h28, 32'h0, 4'hF, 2'd2);
        check("R10 irq masked", {31'b0, irq}, 32'd0);
        bus_write(8'h28, 32'h1, 4'hF, 2'd2);
        check("R10 irq unmasked", {31'b0, irq}, 32'd1);

        // R12 capture ignored while status set
        @(negedge clk);
        cap_valid = 1'b1; cap_info0 = 32'hDEAD_0001; cap_info1 = 32'hDEAD_0002;
        @(negedge clk);
        cap_valid = 1'b0;
        read_check("R12 hold info0", 8'h2C, 32'h0);
        bus_write(8'h24, 32'h1, 4'hF, 2'd2);
        check("R10 irq on clear", {31'b0, irq}, 32'd0);
        @(negedge clk);
        cap_valid = 1'b1; cap_info0 = 32'hFACE_0010; cap_info1 = 32'hFACE_0020;
        @(negedge clk);
        cap_valid = 1'b0;
        read_check("R12 capture info0", 8'h2C, 32'hFACE_0010);
        read_check("R12 capture info1", 8'h30, 32'hFACE_0020);

        // R4 lockdown
        bus_write(8'h00, 32'h8000_0000, 4'hF, 2'd2);
        read_check("R4 lock set", 8'h00, 32'h8000_0000);
        bus_write(8'h00, 32'h0000_0110, 4'hF, 2'd2);
        read_check("R4 control frozen", 8'h00, 32'h8000_0000);
        bus_write(8'h1C, 32'h5555_5555, 4'hF, 2'd2);
        read_check("R4 pointer not stepped", 8'h18, 32'd3);
        lut_rd_idx = 2'd3;
        #1 check("R4 table frozen", lut_rd_word, 32'hDDDD_0004);
        bus_write(8'h28, 32'h0, 4'hF, 2'd2);
        read_check("R4 enable frozen", 8'h28, 32'd1);
        read_check("R4 window read still works", 8'h1C, 32'hDDDD_0004);
        read_check("R6 read step under lock", 8'h18, 32'd0);

        // R3 reset clears everything, including lockdown
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        read_check("R3 control after reset", 8'h00, 32'h0000_0100);
        read_check("R3 enable after reset", 8'h28, 32'd1);
        read_check("R3 info0 after reset", 8'h2C, 32'd0);
        read_check("R3 info1 after reset", 8'h30, 32'd0);
        for (int k = 0; k < NW; k++) begin
            lut_rd_idx = IDXW'(k);
            #1 check($sformatf("R3 table word %0d", k), lut_rd_word, 32'd0);
        end
        bus_write(8'h28, 32'h0, 4'hF, 2'd2);
        read_check("R3 lock released", 8'h28, 32'd0);

        finish_run();
    end
endmodule